// File: doc/BRIEF.md
# Cyclic Prefix Inserter

This block sits after the inverse transform in an OFDM transmit chain. It takes a stream of complex time-domain samples, grouped in symbols of `N_CARRIERS` samples, and emits each symbol with a guard interval in front of it. The guard interval holds a copy of the final `CP_LEN` samples of that symbol. Every symbol on the output therefore lasts `N_CARRIERS + CP_LEN` sample periods. The samples are buffered in a two-bank RAM. One bank fills with the incoming symbol while the other bank is read out.

The block paces its own upstream source. It drives `in_accept` high for the body of each symbol period and low for the guard interval. While `in_accept` is high, the source has to present a new sample on every enabled clock. While `in_accept` is low, the source has to pause. In exchange, the output runs without gaps once the first symbol has been stored. A single enable, `en`, freezes the whole block. The downstream consumer is expected to observe the same enable.

`N_CARRIERS` must be a power of two of at least 2, and `CP_LEN` must lie between 1 and `N_CARRIERS` (for example 8:2, 64:16, 2048:256). Real and imaginary lanes are each `SAMPLE_W` bits wide.

Top module: `cp_inserter`

## Requirements
- R1: A sample pair is stored only on a rising edge where `en` is high and `in_accept` is high. Values on `in_re`/`in_im` at any other edge never appear on the outputs.
- R2: After reset `in_accept` is high. It then repeats a pattern counted in enabled edges: high for exactly `N_CARRIERS` edges, then low for exactly `CP_LEN` edges.
- R3: For every stored symbol x[0..N-1], the output sequence is x[N-CP..N-1] followed by x[0..N-1]. Symbols leave in the order they arrived.
- R4: `out_valid` is low until the (`N_CARRIERS`+1)-th enabled rising edge after reset, and it becomes high at that edge.
- R5: Once `out_valid` is high, it stays high, and each enabled edge presents the next output sample. Symbols follow each other with no idle cycle, provided the source feeds every accepted edge.
- R6: While `en` is low, no state advances. `in_accept`, `out_valid`, `out_re` and `out_im` keep their values.
- R7: Driving `rst_n` low clears the block asynchronously: `out_valid` becomes 0, `in_accept` becomes 1, and any partly stored symbol is discarded. After release the block behaves as it does after power-up.
- R8: `out_re` carries only data taken from `in_re`, and `out_im` carries only data taken from `in_im`. Both are bit-exact copies `SAMPLE_W` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| en | input | 1 | Global clock enable; low freezes all state |
| in_accept | output | 1 | High when an input sample is taken on the next enabled edge |
| in_re | input | SAMPLE_W | Real part of the input sample |
| in_im | input | SAMPLE_W | Imaginary part of the input sample |
| out_valid | output | 1 | Output sample present; stays high once streaming has begun |
| out_re | output | SAMPLE_W | Real part of the output sample |
| out_im | output | SAMPLE_W | Imaginary part of the output sample |

## Verification
The assertions assume two things about the source. First, it treats every enabled edge with `in_accept` high as a transfer. Second, it needs no cycle in which it cannot deliver a sample, so the gap-free output property depends on that. They also assume that `rst_n` is released away from the rising edge, and that a consumer ignores `out_valid` repeats while `en` is low. The stimulus keeps within these limits. It drives a fresh sample at every falling edge that precedes an accepting edge, and distinctive unrelated values everywhere else. It releases reset only at a falling edge and varies `en` at random so that it pauses in all phases of a symbol.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

  // Number of sample lanes carried side by side: real and imaginary.
  localparam int unsigned CPI_LANES = 2;

  // Which part of the symbol period the scheduler is in.
  typedef enum logic {
    SEG_BODY   = 1'b0,
    SEG_PREFIX = 1'b1
  } cpi_seg_e;

endpackage

// File: rtl/cpi_sched.sv
module cpi_sched
  import cpi_pkg::*;
#(
  parameter int unsigned N_CARRIERS = 16,
  parameter int unsigned CP_LEN     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  output logic                         accept_o,
  output logic                         wr_en_o,
  output logic [$clog2(N_CARRIERS):0]  wr_addr_o,
  output logic                         rd_en_o,
  output logic [$clog2(N_CARRIERS):0]  rd_addr_o
);

  localparam int unsigned AW      = $clog2(N_CARRIERS);
  localparam int unsigned SYM_LEN = N_CARRIERS + CP_LEN;
  localparam int unsigned PW      = $clog2(SYM_LEN);
  localparam logic [PW-1:0] PH_LAST = PW'(SYM_LEN - 1);
  localparam logic [PW-1:0] PH_BODY = PW'(N_CARRIERS);
  localparam logic [AW-1:0] CP_MOD  = AW'(CP_LEN % N_CARRIERS);

  logic [PW-1:0] phase_q, phase_d;
  logic          bank_q, bank_d;
  logic          live_q, live_d;
  cpi_seg_e      seg;
  logic [AW-1:0] rd_off;
  logic          rd_bank;

  // Phase counter over one symbol period; write bank flips at the wrap.
  always_comb begin
    phase_d = phase_q;
    bank_d  = bank_q;
    live_d  = live_q;
    if (en) begin
      if (phase_q == PH_LAST) begin
        phase_d = '0;
        bank_d  = ~bank_q;
        live_d  = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bank_q  <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bank_q  <= bank_d;
      live_q  <= live_d;
    end
  end

  assign seg = (phase_q < PH_BODY) ? SEG_BODY : SEG_PREFIX;

  // Prefix part reads the tail of the bank just filled; body part reads
  // the same bank in full while the other bank takes the next symbol.
  assign rd_off  = (seg == SEG_BODY) ? phase_q[AW-1:0] : (phase_q[AW-1:0] - CP_MOD);
  assign rd_bank = (seg == SEG_BODY) ? ~bank_q : bank_q;

  assign accept_o  = (seg == SEG_BODY);
  assign wr_en_o   = en && (seg == SEG_BODY);
  assign wr_addr_o = {bank_q, phase_q[AW-1:0]};
  assign rd_en_o   = en && ((seg == SEG_PREFIX) || live_q);
  assign rd_addr_o = {rd_bank, rd_off};

endmodule

// File: rtl/cpi_bank_ram.sv
module cpi_bank_ram #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5,
  parameter int unsigned W     = 12,
  parameter int unsigned LANES = 2
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [LANES*W-1:0] wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [LANES*W-1:0] rd_data
);

  // One simple dual-port array per lane, registered read with enable.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[wr_addr] <= wr_data[g*W +: W];
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en) begin
        q <= mem[rd_addr];
      end
    end

    assign rd_data[g*W +: W] = q;
  end

endmodule

// File: rtl/cpi_out_stage.sv
module cpi_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rd_go,
  output logic valid_o
);

  logic valid_q, valid_d;

  // Valid follows the read strobe by the RAM read latency of one cycle.
  always_comb begin
    valid_d = valid_q;
    if (en) begin
      valid_d = rd_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/cp_inserter.sv
module cp_inserter
  import cpi_pkg::*;
#(
  parameter int unsigned N_CARRIERS = 16,
  parameter int unsigned CP_LEN     = 4,
  parameter int unsigned SAMPLE_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  output logic                in_accept,
  input  logic [SAMPLE_W-1:0] in_re,
  input  logic [SAMPLE_W-1:0] in_im,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_re,
  output logic [SAMPLE_W-1:0] out_im
);

  localparam int unsigned AW    = $clog2(N_CARRIERS);
  localparam int unsigned DEPTH = 2 * N_CARRIERS;
  localparam int unsigned LW    = CPI_LANES * SAMPLE_W;

  logic          wr_en, rd_en;
  logic [AW:0]   wr_addr, rd_addr;
  logic [LW-1:0] wr_data, rd_data;

  cpi_sched #(
    .N_CARRIERS (N_CARRIERS),
    .CP_LEN     (CP_LEN)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .accept_o  (in_accept),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr)
  );

  // Lane 0 carries the real part, lane 1 the imaginary part.
  assign wr_data = {in_im, in_re};

  cpi_bank_ram #(
    .DEPTH (DEPTH),
    .AW    (AW + 1),
    .W     (SAMPLE_W),
    .LANES (CPI_LANES)
  ) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  cpi_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .rd_go   (rd_en),
    .valid_o (out_valid)
  );

  assign out_re = rd_data[SAMPLE_W-1:0];
  assign out_im = rd_data[LW-1:SAMPLE_W];

endmodule

// File: rtl/cpi_checker.sv
module cpi_checker #(
  parameter int unsigned N  = 16,
  parameter int unsigned CP = 4,
  parameter int unsigned W  = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         in_accept,
  input logic         out_valid,
  input logic [W-1:0] out_re,
  input logic [W-1:0] out_im
);

  localparam int unsigned RW  = $clog2(N + 1);
  localparam int unsigned LAT = N + 1;
  localparam int unsigned EW  = $clog2(N + 2);

  logic [RW-1:0] hi_cnt, lo_cnt;
  logic [EW-1:0] ecnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= '0;
    else if (!in_accept) hi_cnt <= '0;
    else if (en)         hi_cnt <= hi_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lo_cnt <= '0;
    else if (in_accept) lo_cnt <= '0;
    else if (en)        lo_cnt <= lo_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ecnt <= '0;
    else if (en && (ecnt != EW'(LAT)))     ecnt <= ecnt + 1'b1;
  end

  AST_ACCEPT_HIGH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_accept) |-> (hi_cnt == RW'(N))); // R2

  AST_ACCEPT_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_accept) |-> (lo_cnt == RW'(CP))); // R2

  AST_ACCEPT_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !in_accept) |-> (lo_cnt < RW'(CP))); // R2

  AST_FIRST_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (ecnt == EW'(LAT))); // R4

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && out_valid) |=> out_valid); // R5

  AST_FROZEN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(in_accept) && $stable(out_valid))); // R6

  AST_FROZEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && out_valid) |=> ($stable(out_re) && $stable(out_im))); // R6

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_accept && !out_valid)); // R7

endmodule

bind cp_inserter cpi_checker #(
  .N  (N_CARRIERS),
  .CP (CP_LEN),
  .W  (SAMPLE_W)
) u_cpi_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .in_accept (in_accept),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/test_cp_inserter.sv
module test_cp_inserter;

  localparam int N   = 16;
  localparam int CP  = 4;
  localparam int W   = 12;
  localparam int LAT = N + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic         en;
  logic [W-1:0] in_re, in_im;
  logic         in_accept, out_valid;
  logic [W-1:0] out_re, out_im;

  cp_inserter #(
    .N_CARRIERS (N),
    .CP_LEN     (CP),
    .SAMPLE_W   (W)
  ) i_cp_inserter (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .in_accept (in_accept),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [2*W-1:0] sym_buf[$];
  logic [2*W-1:0] exp_q[$];
  int  m_ph, edge_cnt, ramp;
  bit  seen_valid;
  bit  drv_en, drv_acc;
  logic [W-1:0] drv_re, drv_im;
  bit  prev_valid, prev_acc;
  logic [W-1:0] prev_re, prev_im;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    sym_buf.delete();
    exp_q.delete();
    m_ph       = 0;
    edge_cnt   = 0;
    seen_valid = 0;
    prev_valid = 0;
    prev_acc   = 1;
    drv_en     = 0;
  endtask

  // Judge the outcome of the rising edge that just passed.
  task automatic evaluate();
    logic [2*W-1:0] e;
    if (drv_en) begin
      edge_cnt++;
      if (exp_q.size() > 0) begin
        chk(out_valid === 1'b1, "R5", "out_valid while streaming", int'(out_valid), 1);
        if (out_valid === 1'b1) begin
          e = exp_q.pop_front();
          // R1: samples offered while not accepted never enter exp_q
          chk(out_re === e[W-1:0], "R3", "out_re sample (R8 real lane)",
              int'(out_re), int'(e[W-1:0]));
          chk(out_im === e[2*W-1:W], "R8", "out_im sample (R3 order)",
              int'(out_im), int'(e[2*W-1:W]));
        end
      end else begin
        chk(out_valid === 1'b0, "R4", "out_valid before first symbol", int'(out_valid), 0);
      end
      if (out_valid === 1'b1 && !seen_valid) begin
        seen_valid = 1;
        chk(edge_cnt == LAT, "R4", "enabled edge of first output", edge_cnt, LAT);
      end
      m_ph = (m_ph == N + CP - 1) ? 0 : m_ph + 1;
      chk(in_accept === (m_ph < N), "R2", "in_accept pattern", int'(in_accept), int'(m_ph < N));
      if (drv_acc) begin
        sym_buf.push_back({drv_im, drv_re});
        if (sym_buf.size() == N) begin
          for (int j = N - CP; j < N; j++) exp_q.push_back(sym_buf[j]);
          for (int j = 0; j < N; j++) exp_q.push_back(sym_buf[j]);
          sym_buf.delete();
        end
      end
    end else begin
      chk(out_valid === prev_valid, "R6", "out_valid held", int'(out_valid), int'(prev_valid));
      chk(in_accept === prev_acc, "R6", "in_accept held", int'(in_accept), int'(prev_acc));
      if (prev_valid) begin
        chk(out_re === prev_re, "R6", "out_re held", int'(out_re), int'(prev_re));
        chk(out_im === prev_im, "R6", "out_im held", int'(out_im), int'(prev_im));
      end
    end
    prev_valid = out_valid;
    prev_acc   = in_accept;
    prev_re    = out_re;
    prev_im    = out_im;
  endtask

  // Drive inputs for the next rising edge.
  task automatic drive(input int mode, input int idle_pct);
    drv_en  = ($urandom_range(99) >= idle_pct);
    drv_acc = in_accept;
    if (drv_en && drv_acc) begin
      case (mode)
        0: begin
          drv_re = W'(ramp);
          drv_im = ~W'(ramp * 3);
        end
        1: begin
          drv_re = W'($urandom);
          drv_im = W'($urandom);
        end
        default: begin
          drv_re = ramp[0] ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}};
          drv_im = ramp[0] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
      endcase
      ramp++;
    end else begin
      drv_re = W'($urandom) | W'(1);
      drv_im = W'($urandom) & ~W'(1);
    end
    en    = drv_en;
    in_re = drv_re;
    in_im = drv_im;
  endtask

  task automatic run(input int mode, input int idle_pct, input int cycles);
    repeat (cycles) begin
      @(negedge clk);
      evaluate();
      drive(mode, idle_pct);
    end
  endtask

  task automatic async_reset();
    #3;
    rst_n = 1'b0;
    #1;
    chk(out_valid === 1'b0, "R7", "out_valid during async reset", int'(out_valid), 0);
    chk(in_accept === 1'b1, "R7", "in_accept during async reset", int'(in_accept), 1);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    in_re = '0;
    in_im = '0;
    ramp  = 1;
    model_reset();
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);
    chk(in_accept === 1'b1, "R7", "in_accept after reset", int'(in_accept), 1);
    rst_n = 1'b1;

    run(0, 0, 200);   // steady ramp, no pauses
    run(1, 20, 400);  // random data, random enable pauses
    run(2, 0, 150);   // full-scale alternation on both lanes
    async_reset();
    run(0, 0, 120);   // restart latency after reset
    run(1, 35, 240);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual run still active, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule